// File: doc/BRIEF.md
# Pipelined Converter Capture Stage with Standby Blanking

This block sits in the sampling clock domain of a 10-bit parallel pipelined analog-to-digital converter. It registers the converter's output word on every rising clock edge. It also owns the two control lines the converter reads: a power-down request and an output-format select. A small write port sets both lines.

Downstream logic gets a single representation: signed two's complement, with an over-range flag, an under-range flag and a qualifier. The block tracks which format the converter was using when each sample entered the converter's internal pipeline. That sample is converted correctly even when the format select changed while it was in flight. The qualifier stays low after reset, while the converter is powered down, and during the recovery interval after power-up. After that it is high on every cycle.

The converter's pipeline delay (6 cycles) and exit-recovery time (20 cycles) are parameters. The blanking window is the longer of the recovery time and the pipeline-plus-capture fill.

Top module: `adc_capture_blank`

## Requirements
- R1: While rst_n is low, adc_standby, adc_twos, smp_valid, smp_over, smp_under and smp_data are all 0.
- R2: adc_standby and adc_twos load cfg_standby and cfg_twos on a rising edge where cfg_wr is 1. On edges where cfg_wr is 0 they keep their values, whatever the cfg_standby and cfg_twos inputs carry.
- R3: The output registers after edge e describe the word present on adc_data just before edge e. The converter presents a sample taken at edge m just before edge m+7, which is 6 cycles of converter latency plus one capture register.
- R4: A sample taken while adc_twos was 0 is offset binary. smp_data equals that word with bit 9 inverted.
- R5: A sample taken while adc_twos was 1 is already two's complement. smp_data equals the word unchanged.
- R6: The format used for each word is the value adc_twos held 7 edges before the capture edge. A change of adc_twos does not disturb samples already inside the converter pipeline.
- R7: smp_over is 1 exactly when smp_valid is 1 and the offset-binary equivalent of the sample is 1023, which is +511 on smp_data.
- R8: smp_under is 1 exactly when smp_valid is 1 and the offset-binary equivalent of the sample is 0, which is -512 on smp_data.
- R9: When smp_valid is 0, smp_over and smp_under are both 0.
- R10: smp_valid drops to 0 on the edge that writes adc_standby to 1, and stays 0 while adc_standby is 1.
- R11: smp_valid goes high after the 20th rising edge that follows reset release or the edge that cleared adc_standby. It then stays high on every cycle until standby is requested again.
- R12: A standby request made during the recovery window restarts the 20-edge count from the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the control fields |
| cfg_standby | input | 1 | Power-down request value to load |
| cfg_twos | input | 1 | Format select value to load (1 = two's complement) |
| adc_data | input | 10 | Parallel word from the converter |
| adc_standby | output | 1 | Power-down line to the converter |
| adc_twos | output | 1 | Format select line to the converter |
| smp_data | output | 10 | Normalised sample, two's complement |
| smp_valid | output | 1 | Sample qualifier |
| smp_over | output | 1 | Over-range code flag |
| smp_under | output | 1 | Under-range code flag |

## Verification
The checker's properties assume the converter behaves as the requirements describe. Every word arrives exactly 6 edges after its sample in the format that applied at sampling, and words produced during power-down may be anything. The bench's converter model keeps a 16-entry history of sampled codes and format settings and replays them with that latency. It deliberately drives a scrambled word for every sample taken in power-down, so that any sample wrongly qualified shows up as a data mismatch. The stimulus also holds the write strobe to single-cycle pulses, and it issues standby requests only at points where the window counters can be checked against the 20-edge rule.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  // Blanking length: the converter's exit-recovery time, or the pipeline
  // fill including the capture register, whichever is longer.
  function automatic int unsigned blank_len(input int unsigned exit_cyc,
                                            input int unsigned lat);
    return (exit_cyc > lat + 1) ? exit_cyc : lat + 1;
  endfunction

  // Width needed to count from 0 to n inclusive.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_standby,
  input  logic cfg_twos,
  output logic stby_q,
  output logic twos_q,
  output logic stby_d
);

  // Value the standby line will carry after this edge.
  always_comb stby_d = cfg_wr ? cfg_standby : stby_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stby_q <= 1'b0;
      twos_q <= 1'b0;
    end else if (cfg_wr) begin
      stby_q <= cfg_standby;
      twos_q <= cfg_twos;
    end
  end

endmodule

// File: rtl/fmt_history.sv
module fmt_history #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] taps;

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tap
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) taps[gi] <= 1'b0;
          else        taps[gi] <= d;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) taps[gi] <= 1'b0;
          else        taps[gi] <= taps[gi-1];
        end
      end
    end
  endgenerate

  assign q = taps[DEPTH-1];

endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int HOLD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_now,
  input  logic stby_next,
  output logic valid_next,
  output logic recov_done
);

  localparam int CW = adc_cap_pkg::cnt_width(HOLD);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Counts edges with the standby line low; any request clears it.
  always_comb begin
    if (stby_next || stby_now) cnt_d = '0;
    else if (cnt_q == HOLD_C)  cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  assign recov_done = (cnt_d == HOLD_C);
  assign valid_next = !stby_next && recov_done;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sample_norm.sv
module sample_norm #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] raw,
  input  logic          twos_sel,
  input  logic          take,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_over,
  output logic          out_under
);

  localparam logic [DW-1:0] MSB_BIT = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] TOP_CODE = '1;

  // Offset-binary equivalent of a converter word.
  function automatic logic [DW-1:0] as_offset(input logic [DW-1:0] w,
                                              input logic t);
    return t ? (w ^ MSB_BIT) : w;
  endfunction

  // Two's complement equivalent of a converter word.
  function automatic logic [DW-1:0] as_signed(input logic [DW-1:0] w,
                                              input logic t);
    return t ? w : (w ^ MSB_BIT);
  endfunction

  logic [DW-1:0] off_code;
  logic          over_hit;
  logic          under_hit;

  always_comb begin
    off_code  = as_offset(raw, twos_sel);
    over_hit  = take && (off_code == TOP_CODE);
    under_hit = take && (off_code == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_over  <= 1'b0;
      out_under <= 1'b0;
    end else begin
      out_data  <= as_signed(raw, twos_sel);
      out_valid <= take;
      out_over  <= over_hit;
      out_under <= under_hit;
    end
  end

endmodule

// File: rtl/adc_capture_blank.sv
module adc_capture_blank #(
  parameter int DW       = 10,
  parameter int LAT      = 6,
  parameter int EXIT_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_standby,
  input  logic          cfg_twos,
  input  logic [DW-1:0] adc_data,
  output logic          adc_standby,
  output logic          adc_twos,
  output logic [DW-1:0] smp_data,
  output logic          smp_valid,
  output logic          smp_over,
  output logic          smp_under
);

  localparam int HOLD   = adc_cap_pkg::blank_len(EXIT_CYC, LAT);
  localparam int FDEPTH = LAT + 1;

  // Named internal events, observed by the bound checker.
  logic stby_nx;
  logic fmt_sel;
  logic valid_nx;
  logic recov_done;

  adc_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_standby(cfg_standby),
    .cfg_twos   (cfg_twos),
    .stby_q     (adc_standby),
    .twos_q     (adc_twos),
    .stby_d     (stby_nx)
  );

  fmt_history #(.DEPTH(FDEPTH)) u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (adc_twos),
    .q    (fmt_sel)
  );

  blank_timer #(.HOLD(HOLD)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_now  (adc_standby),
    .stby_next (stby_nx),
    .valid_next(valid_nx),
    .recov_done(recov_done)
  );

  sample_norm #(.DW(DW)) u_norm (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (adc_data),
    .twos_sel (fmt_sel),
    .take     (valid_nx && recov_done),
    .out_data (smp_data),
    .out_valid(smp_valid),
    .out_over (smp_over),
    .out_under(smp_under)
  );

endmodule

// File: rtl/adc_capture_blank_chk.sv
module adc_capture_blank_chk #(
  parameter int DW   = 10,
  parameter int HOLD = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          cfg_standby,
  input logic          adc_standby,
  input logic          adc_twos,
  input logic          valid_nx,
  input logic [DW-1:0] smp_data,
  input logic          smp_valid,
  input logic          smp_over,
  input logic          smp_under
);

  localparam int CW = adc_cap_pkg::cnt_width(HOLD);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  // Edges since the standby line was last seen low after a release.
  logic [CW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)               since_q <= '0;
    else if (adc_standby)     since_q <= '0;
    else if (since_q < HOLD_C) since_q <= since_q + 1'b1;
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(adc_standby) && $stable(adc_twos)));

  // R10
  stby_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_standby |-> !smp_valid);

  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_standby) |-> !valid_nx);

  // R11
  early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (since_q == HOLD_C));

  // R11
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !(cfg_wr && cfg_standby)) |=> smp_valid);

  // R9
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> (!smp_over && !smp_under));

  // R7
  over_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_over == (smp_data == POS_MAX)));

  // R8
  under_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_under == (smp_data == NEG_MIN)));

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_over, smp_under}));

endmodule

bind adc_capture_blank adc_capture_blank_chk #(.DW(DW), .HOLD(HOLD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_standby(cfg_standby),
  .adc_standby(adc_standby),
  .adc_twos   (adc_twos),
  .valid_nx   (valid_nx),
  .smp_data   (smp_data),
  .smp_valid  (smp_valid),
  .smp_over   (smp_over),
  .smp_under  (smp_under)
);

// File: tb/test_adc_capture_blank.sv
`timescale 1ns/1ps
module test_adc_capture_blank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_standby = 1'b0;
  logic       cfg_twos = 1'b0;
  logic [9:0] adc_data = '0;
  logic       adc_standby, adc_twos;
  logic [9:0] smp_data;
  logic       smp_valid, smp_over, smp_under;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rel = 0;

  logic [9:0] word_r [16];
  logic       fmt_r  [16];

  always #2 clk = ~clk;

  adc_capture_blank i_adc_capture_blank (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_standby(cfg_standby),
    .cfg_twos(cfg_twos), .adc_data(adc_data), .adc_standby(adc_standby),
    .adc_twos(adc_twos), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_over(smp_over), .smp_under(smp_under)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Called just after a falling edge: drives one cycle, checks after the rise.
  task automatic tick(input logic wr, input logic sb, input logic tw,
                      input int code, input string ph);
    int n;
    logic sb_before, sb_after, tw_after, ev, f;
    logic [9:0] w, off, expd;
    n = cyc + 1;
    cfg_wr = wr; cfg_standby = sb; cfg_twos = tw;
    // Converter model: sample n taken at the coming edge, shown 6 edges later.
    fmt_r[n & 15] = adc_twos;
    if (adc_standby) word_r[n & 15] = 10'(n * 37) ^ 10'h2A5;
    else             word_r[n & 15] = adc_twos ? (10'(code) ^ 10'h200) : 10'(code);
    adc_data  = word_r[(n - 7) & 15];
    sb_before = adc_standby;
    sb_after  = wr ? sb : sb_before;
    tw_after  = wr ? tw : adc_twos;
    @(posedge clk);
    cyc = n;
    if (sb_before) rel = 0; else rel++;
    ev = !sb_after && (rel >= 20);
    #1;
    chk({"R2 standby ", ph}, int'(adc_standby), int'(sb_after));
    chk({"R2 format ", ph},  int'(adc_twos),    int'(tw_after));
    chk({sb_after ? "R10 valid " : "R11 R12 valid ", ph}, int'(smp_valid), int'(ev));
    if (ev) begin
      w    = word_r[(n - 7) & 15];
      f    = fmt_r[(n - 7) & 15];
      off  = f ? (w ^ 10'h200) : w;
      expd = off ^ 10'h200;
      chk({f ? "R3 R5 R6 data " : "R3 R4 R6 data ", ph}, int'(smp_data), int'(expd));
      chk({"R7 over ", ph},  int'(smp_over),  int'(off == 10'h3FF));
      chk({"R8 under ", ph}, int'(smp_under), int'(off == 10'h000));
    end else begin
      chk({"R9 flags ", ph}, int'({smp_over, smp_under}), 0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin word_r[i] = '0; fmt_r[i] = 1'b0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1 standby", int'(adc_standby), 0);
    chk("R1 format",  int'(adc_twos), 0);
    chk("R1 valid",   int'(smp_valid), 0);
    chk("R1 flags",   int'({smp_over, smp_under}), 0);
    chk("R1 data",    int'(smp_data), 0);
    rst_n = 1'b1;
    rel = 0;
    // R11: blanking after reset, then full offset-binary sweep (R4 R7 R8)
    for (int c = 0; c < 1050; c++) tick(1'b0, 1'b0, 1'b0, c & 1023, "offset sweep");
    // R5 R6: switch to two's complement mid-stream and sweep again
    tick(1'b1, 1'b0, 1'b1, 511, "to twos");
    for (int c = 0; c < 1040; c++) tick(1'b0, 1'b0, 1'b0, (c * 5) & 1023, "twos sweep");
    // R10: power-down, hold, release
    tick(1'b1, 1'b1, 1'b1, 3, "standby on");
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, 1023, "in standby");
    tick(1'b1, 1'b0, 1'b1, 0, "release");
    // R12: re-request during recovery, then full recovery
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, 1'b0, i * 11, "recovering");
    tick(1'b1, 1'b1, 1'b0, 7, "re-request");
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, 0, "in standby 2");
    tick(1'b1, 1'b0, 1'b0, 0, "release 2");
    for (int i = 0; i < 30; i++) tick(1'b0, 1'b0, 1'b0, (i * 71) & 1023, "recover 2");
    // R2: field values without the strobe have no effect
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b1, 1'b1, 1023 - i, "no strobe");
    // R6: frequent format changes while samples are in flight
    for (int i = 0; i < 240; i++)
      tick((i % 5) == 0, 1'b0, ((i / 5) & 1) == 1, (i * 97) & 1023, "format toggle");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule